// File: doc/BRIEF.md
# Relocatable Configuration Port Decoder

This block owns the 16-bit I/O base address of a two-port configuration window and matches every host I/O cycle against it. The index port sits at the base and the data port at the base plus one. When reset ends, a 2-bit strap input picks one of four fixed even base addresses.

Software moves the window from inside the configuration state. The host writes the new low address byte through a relocation register, then the new high byte through a second relocation register. The low-byte write is only held in a staging register. The high-byte write puts the staged low byte and the new high byte into the decoder together, so the decoder never matches a half-updated address. The caller supplies the register index that was selected through the index port, and it supplies the configuration-state flag.

Top module: `cfg_port_decoder`

## Requirements
- R1: Reset is synchronous and active low. After reset the active base is set by `strap`: 00 gives 0x002E, 01 gives 0x004E, 10 gives 0x015C, 11 gives 0x03F0.
- R2: `index_hit` is high in the same cycle as an access (`io_rd` or `io_wr` high) whose `io_addr` equals the base. `data_hit` is high in the same cycle as an access whose `io_addr` equals the base plus one. Neither output is high when no strobe is active.
- R3: A register write is a data-port write while `cfg_state` is high. With `reg_idx` = 0x12 it only stages the low byte, and the decoded base stays the same.
- R4: A register write with `reg_idx` = 0x13 makes the base {written byte, staged low byte}. The new base takes effect in the cycle after the write.
- R5: Bit 0 of the written low byte is dropped, so the base is always even.
- R6: A data-port read while `cfg_state` is high returns the committed base on `rd_data` in the same cycle. It returns bits 7:0 for index 0x12 and bits 15:8 for index 0x13, and never the staged value.
- R7: While `cfg_state` is low, writes to either register have no effect and `rd_data` is zero.
- R8: If the high byte is written with no low-byte write since reset, the low byte of the committed base stays the same.
- R9: `rd_data` is zero except during a data-port read with `reg_idx` = 0x12 or 0x13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap | input | 2 | Selects the power-up base address |
| cfg_state | input | 1 | High while the configuration state is active |
| reg_idx | input | 8 | Configuration register currently selected |
| io_addr | input | 16 | Host I/O address |
| io_wdata | input | 8 | Host write data |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| index_hit | output | 1 | Access matches the index port |
| data_hit | output | 1 | Access matches the data port |
| rd_data | output | 8 | Relocation register read data |

## Verification
A wrong base register shows up on the very next access. The hit outputs fire at the wrong address, or the read-back of either relocation register gives the wrong byte in the same cycle. A staging fault stays hidden until the high byte is committed. It then shows on the first access after the commit, as a missed hit at the expected new address or an odd base. For this reason the bench reads both registers and probes the old and new ports right after every commit.

// File: rtl/cfgdec_pkg.sv
// Package: shared constants and the strap-to-base table for the configuration
// port decoder. Assumes a 16-bit base built from two 8-bit register bytes.
package cfgdec_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int IDX_W  = 8;
    localparam logic [IDX_W-1:0] IDX_BASE_LO = 8'h12;
    localparam logic [IDX_W-1:0] IDX_BASE_HI = 8'h13;

    typedef logic [ADDR_W-1:0] base_t;

    // Maps a strap code to its fixed power-up base address.
    function automatic base_t strap_base(input logic [1:0] code);
        case (code)
            2'b00:   return 16'h002E;
            2'b01:   return 16'h004E;
            2'b10:   return 16'h015C;
            default: return 16'h03F0;
        endcase
    endfunction
endpackage

// File: rtl/cfgdec_strap_sel.sv
// Module: turns the strap pins into the default base address.
// Purely combinational. Assumes the strap pins are stable while reset is asserted.
module cfgdec_strap_sel
    import cfgdec_pkg::*;
(
    input  logic [1:0]        strap,
    output logic [ADDR_W-1:0] dflt_base
);
    // Table lookup for the default base.
    always_comb dflt_base = strap_base(strap);
endmodule

// File: rtl/cfgdec_base_reg.sv
// Module: holds the committed base and the staged low byte.
// A low-byte write only updates the stage. A high-byte write commits the
// stage and the new high byte together. Assumes the write enables are
// already qualified by the configuration state and a data-port hit.
module cfgdec_base_reg
    import cfgdec_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] dflt_base,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic [DW-1:0] wdata,
    output logic [AW-1:0] base
);
    localparam logic [DW-1:0] EVEN_MASK = {{(DW-1){1'b1}}, 1'b0};

    logic [DW-1:0] staged_lo;

    // Staging register for the low byte. Bit 0 is dropped to keep the base even.
    always_ff @(posedge clk) begin
        if (!rst_n)     staged_lo <= dflt_base[DW-1:0] & EVEN_MASK;
        else if (wr_lo) staged_lo <= wdata & EVEN_MASK;
    end

    // Committed base. It changes only on a high-byte write.
    always_ff @(posedge clk) begin
        if (!rst_n)     base <= {dflt_base[AW-1:DW], dflt_base[DW-1:0] & EVEN_MASK};
        else if (wr_hi) base <= {wdata, staged_lo};
    end

    AST_LO_ONLY_STAGES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !wr_hi) |=> $stable(base)); // R3
    AST_HI_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> base[AW-1:DW] == $past(wdata)); // R4
    AST_BASE_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> !base[0]); // R5
endmodule

// File: rtl/cfgdec_port_match.sv
// Module: compares one I/O access with the index and data port addresses.
// Combinational. Assumes the base is even, so base+1 cannot carry past bit 15.
module cfgdec_port_match
    import cfgdec_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] io_addr,
    input  logic          strobe,
    output logic          index_hit,
    output logic          data_hit
);
    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    // Same-cycle address compare for both ports.
    always_comb begin
        index_hit = strobe && (io_addr == base);
        data_hit  = strobe && (io_addr == (base | ONE));
    end
endmodule

// File: rtl/cfg_port_decoder.sv
// Module: top of the relocatable configuration port decoder.
// Gates the register accesses with the configuration state and the selected
// index, and drives the read-back mux. Assumes single-cycle I/O strobes.
module cfg_port_decoder
    import cfgdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        strap,
    input  logic              cfg_state,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              io_wr,
    input  logic              io_rd,
    output logic              index_hit,
    output logic              data_hit,
    output logic [DATA_W-1:0] rd_data
);
    logic [ADDR_W-1:0] dflt_base;
    logic [ADDR_W-1:0] base;
    logic              reg_access;
    logic              wr_lo, wr_hi;

    cfgdec_strap_sel u_strap (
        .strap     (strap),
        .dflt_base (dflt_base)
    );

    cfgdec_port_match #(.AW(ADDR_W)) u_match (
        .base      (base),
        .io_addr   (io_addr),
        .strobe    (io_rd | io_wr),
        .index_hit (index_hit),
        .data_hit  (data_hit)
    );

    // A register access is a data-port access inside the configuration state.
    always_comb begin
        reg_access = data_hit && cfg_state;
        wr_lo      = reg_access && io_wr && (reg_idx == IDX_BASE_LO);
        wr_hi      = reg_access && io_wr && (reg_idx == IDX_BASE_HI);
    end

    cfgdec_base_reg #(.AW(ADDR_W), .DW(DATA_W)) u_base (
        .clk       (clk),
        .rst_n     (rst_n),
        .dflt_base (dflt_base),
        .wr_lo     (wr_lo),
        .wr_hi     (wr_hi),
        .wdata     (io_wdata),
        .base      (base)
    );

    // Read-back mux. It returns the committed bytes, or zero when not selected.
    always_comb begin
        rd_data = '0;
        if (reg_access && io_rd) begin
            if (reg_idx == IDX_BASE_LO)      rd_data = base[DATA_W-1:0];
            else if (reg_idx == IDX_BASE_HI) rd_data = base[ADDR_W-1:DATA_W];
        end
    end

    AST_HITS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(index_hit && data_hit)); // R2
    AST_NO_STROBE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_rd || io_wr) |-> !(index_hit || data_hit)); // R2
    AST_IDX_PORT_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        index_hit |-> !io_addr[0]); // R5
    AST_OUTSIDE_CFG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_state |-> rd_data == '0); // R7
    AST_OUTSIDE_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !cfg_state) |=> $stable(base)); // R7
endmodule

// File: tb/cfg_port_decoder_tb_top.sv
// Bench: directed corner cases plus seeded random traffic, checked against a
// reference model of the base and the staged byte.
module cfg_port_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  strap;
    logic        cfg_state;
    logic [7:0]  reg_idx;
    logic [15:0] io_addr;
    logic [7:0]  io_wdata;
    logic        io_wr, io_rd;
    logic        index_hit, data_hit;
    logic [7:0]  rd_data;

    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] m_base;
    logic [7:0]  m_stage;

    always #10 clk = ~clk; // 50 MHz

    cfg_port_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .strap(strap), .cfg_state(cfg_state),
        .reg_idx(reg_idx), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_wr(io_wr), .io_rd(io_rd), .index_hit(index_hit),
        .data_hit(data_hit), .rd_data(rd_data)
    );

    function automatic logic [15:0] f_dflt(input logic [1:0] s);
        case (s)
            2'b00: return 16'h002E;
            2'b01: return 16'h004E;
            2'b10: return 16'h015C;
            default: return 16'h03F0;
        endcase
    endfunction

    function automatic logic [7:0] f_rd(input logic [15:0] a, input logic rd,
                                        input logic cs, input logic [7:0] idx);
        if (!(rd && cs && a == m_base + 16'd1)) return 8'h00;
        if (idx == 8'h12) return m_base[7:0];
        if (idx == 8'h13) return m_base[15:8];
        return 8'h00;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drives one access at the falling edge, checks the outputs mid-phase, then updates the model.
    task automatic access(input string req, input logic [15:0] a, input logic wr,
                          input logic rd, input logic cs, input logic [7:0] idx,
                          input logic [7:0] d);
        logic acc;
        io_addr = a; io_wr = wr; io_rd = rd; cfg_state = cs; reg_idx = idx; io_wdata = d;
        #5;
        acc = wr | rd;
        check({req, " index_hit"}, {15'd0, index_hit}, {15'd0, acc && a == m_base});
        check({req, " data_hit"},  {15'd0, data_hit},  {15'd0, acc && a == m_base + 16'd1});
        check({req, " rd_data"},   {8'd0, rd_data},    {8'd0, f_rd(a, rd, cs, idx)});
        @(posedge clk);
        if (wr && cs && a == m_base + 16'd1) begin
            if (idx == 8'h12) m_stage = d & 8'hFE;
            else if (idx == 8'h13) m_base = {d, m_stage};
        end
        @(negedge clk);
        io_wr = 1'b0; io_rd = 1'b0;
    endtask

    task automatic do_reset(input logic [1:0] s);
        strap = s; rst_n = 1'b0;
        io_wr = 1'b0; io_rd = 1'b0; cfg_state = 1'b0; reg_idx = 8'h00;
        io_addr = 16'h0; io_wdata = 8'h0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_base = f_dflt(s); m_stage = m_base[7:0];
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'hC0F1));
        // R1 / R6: each strap default reads back through both registers.
        for (int s = 0; s < 4; s++) begin
            do_reset(s[1:0]);
            access("R1", m_base, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00);
            access("R6", m_base + 16'd1, 1'b0, 1'b1, 1'b1, 8'h12, 8'h00);
            access("R6", m_base + 16'd1, 1'b0, 1'b1, 1'b1, 8'h13, 8'h00);
        end
        // R8: high byte only keeps the low byte.
        do_reset(2'b10);
        access("R8", m_base + 16'd1, 1'b1, 1'b0, 1'b1, 8'h13, 8'h21);
        check("R8 base", m_base, 16'h215C);
        access("R8", 16'h215C, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00);
        // R3 / R5 / R6: a staged odd low byte is not visible and not decoded.
        access("R3", m_base + 16'd1, 1'b1, 1'b0, 1'b1, 8'h12, 8'h81);
        access("R3", 16'h215C, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
        access("R6", m_base + 16'd1, 1'b0, 1'b1, 1'b1, 8'h12, 8'h00);
        // R4 / R5: commit the new base, then probe old and new ports.
        access("R4", m_base + 16'd1, 1'b1, 1'b0, 1'b1, 8'h13, 8'h7A);
        check("R4/R5 base", m_base, 16'h7A80);
        access("R4 new", 16'h7A80, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00);
        access("R4 new data", 16'h7A81, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
        access("R4 old", 16'h215C, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00);
        // R7: writes outside the configuration state are ignored.
        access("R7", m_base + 16'd1, 1'b1, 1'b0, 1'b0, 8'h12, 8'h44);
        access("R7", m_base + 16'd1, 1'b1, 1'b0, 1'b0, 8'h13, 8'h55);
        access("R7 rd", m_base + 16'd1, 1'b0, 1'b1, 1'b0, 8'h13, 8'h00);
        access("R7 keep", 16'h7A80, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00);
        // R9: other index reads zero. R2: no strobe gives no hit.
        access("R9", m_base + 16'd1, 1'b0, 1'b1, 1'b1, 8'h07, 8'h00);
        access("R2", m_base, 1'b0, 1'b0, 1'b1, 8'h12, 8'h00);
        // Random traffic mixing register writes, reads and stray accesses.
        for (int i = 0; i < 600; i++) begin
            logic [3:0]  op;
            logic [15:0] a;
            logic [7:0]  idx;
            op  = 4'($urandom_range(0, 15));
            idx = (op[0]) ? 8'h13 : ((op[1]) ? 8'h12 : 8'($urandom));
            case (op[3:2])
                2'd0: a = m_base;
                2'd1, 2'd2: a = m_base + 16'd1;
                default: a = 16'($urandom);
            endcase
            access("R2/R3/R4/R6/R7", a, op[1] ^ op[2], ~(op[1] ^ op[2]),
                   ($urandom_range(0, 7) != 0), idx, 8'($urandom));
        end
        finish_run();
    end
endmodule